// File: doc/BRIEF.md
# DMA Control Register Block with AXI4-Lite Slave

This block is the software-facing register file of a read-only storage DMA engine. A processor reaches it over an AXI4-Lite slave port with 32-bit address and data, decoded inside a 4 KB window. Software programs a memory target address, a first sector and an even sector count. It then arms the engine by writing a go bit. While the engine runs, software can poll its busy flag, error flag, protocol state code, card class and byte progress.

The block turns register writes into single-cycle command pulses: one to launch a transfer and one to reset the engine. It raises a pending flag each time the engine leaves the busy condition. Software can mask that flag onto an active-high interrupt line and clears it by writing a one to it. The DMA datapath and the card protocol sit outside this block. They connect through plain status inputs and configuration outputs.

Top module: `dma_csr_axil`

## Requirements
- R1: After reset, both response channels are idle, the interrupt and both pulses are low, and the control, target address and sector count registers read 0.
- R2: The write address and write data may be accepted in either order or together. The write response is raised only after both have been accepted, stays up until taken, and always carries response code 00 (OKAY).
- R3: A read response stays valid with stable data until it is taken and always carries response code 00. Offsets outside the seven registers, such as 0x1C and 0x100, read as 0.
- R4: The target address (offset 0x08) and first sector (offset 0x0C) are full 32-bit read/write registers, and each byte lane is written only when its write strobe bit is set.
- R5: The sector count (offset 0x10) stores only bits 22:1. Bit 0 and bits 31:23 always read 0.
- R6: In the control register (offset 0x00), bit 1 is a stored interrupt enable. Writing 1 to bit 0 while idle produces exactly one single-cycle start pulse, and bit 0 reads 0.
- R7: Writing 1 to control bit 0 while the busy input is high produces no start pulse.
- R8: The status register (offset 0x04) reads as follows: bits 8:5 the state code input, bits 4:3 the card class input, bit 2 interrupt pending, bit 1 the DMA error input, bit 0 the busy input, and zeros above.
- R9: Pending is set one cycle after busy falls. Writing 1 to status bit 2 clears it, and writing 0 there leaves it set.
- R10: The interrupt output is high exactly when pending and enable are both set.
- R11: Writing 1 to bit 0 of offset 0x18 produces one single-cycle soft-reset pulse, and that bit reads 0.
- R12: Offset 0x14 reads the progress input. Writes to read-only or unmapped offsets get an OKAY response and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 32 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 32 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| busy_i | input | 1 | Engine transfer in progress |
| dma_err_i | input | 1 | Engine memory write error |
| state_i | input | 4 | Engine protocol state code |
| card_type_i | input | 2 | Detected card class |
| progress_i | input | 32 | Bytes moved so far |
| dst_addr_o | output | 32 | Memory target address |
| start_sector_o | output | 32 | First sector to read |
| sector_count_o | output | 32 | Sector count, bit 0 always 0 |
| start_o | output | 1 | One-cycle transfer launch |
| soft_rst_o | output | 1 | One-cycle engine reset |
| irq_o | output | 1 | Active-high interrupt |

## Verification
A wrong pending or enable bit shows on irq_o within one cycle of the event that should have changed it, so the interrupt line is compared with a bench model on every clock. A write latched into the wrong register, or under the wrong byte strobes, shows only on a later read of that offset. For that reason every write is followed by reading back the affected register and a neighbour it must not touch. A lost or duplicated command bit shows as a wrong count of start or soft-reset pulses, checked a cycle after each write response.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_STAT  = 3'd1,
      SEL_DST   = 3'd2,
      SEL_SECT  = 3'd3,
      SEL_CNT   = 3'd4,
      SEL_PROG  = 3'd5,
      SEL_KICK  = 3'd6,
      SEL_NONE  = 3'd7
   } csr_sel_e;

   // control word
   localparam int unsigned GO_BIT     = 0;
   localparam int unsigned IEN_BIT    = 1;
   // status word
   localparam int unsigned BUSY_BIT   = 0;
   localparam int unsigned ERR_BIT    = 1;
   localparam int unsigned PEND_BIT   = 2;
   localparam int unsigned CTYPE_LSB  = 3;
   localparam int unsigned CSTATE_LSB = 5;
   // soft reset word
   localparam int unsigned KICK_BIT   = 0;

   localparam logic [1:0] RESP_OKAY   = 2'b00;

endpackage

// File: rtl/dma_csr_wr_port.sv
module dma_csr_wr_port #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic              bvalid,
   input  logic              bready,
   output logic              commit,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data,
   output logic [STRB_W-1:0] commit_strb
);

   logic aw_full, w_full, resp_q;

   assign awready = !aw_full && !resp_q;
   assign wready  = !w_full && !resp_q;
   assign commit  = aw_full && w_full && !resp_q;
   assign bvalid  = resp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_full     <= 1'b0;
         w_full      <= 1'b0;
         resp_q      <= 1'b0;
         commit_addr <= '0;
         commit_data <= '0;
         commit_strb <= '0;
      end else begin
         if (awvalid && awready) begin
            aw_full     <= 1'b1;
            commit_addr <= awaddr;
         end
         if (wvalid && wready) begin
            w_full      <= 1'b1;
            commit_data <= wdata;
            commit_strb <= wstrb;
         end
         if (commit) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            resp_q  <= 1'b1;
         end else if (resp_q && bready) begin
            resp_q  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dma_csr_rd_port.sv
module dma_csr_rd_port #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   input  logic              rready,
   output logic [ADDR_W-1:0] look_addr,
   input  logic [DATA_W-1:0] look_data
);

   logic valid_q;

   assign arready   = !valid_q;
   assign rvalid    = valid_q;
   assign look_addr = araddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         rdata   <= '0;
      end else if (arvalid && arready) begin
         valid_q <= 1'b1;
         rdata   <= look_data;
      end else if (valid_q && rready) begin
         valid_q <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_csr_core.sv
module dma_csr_core
   import dma_csr_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned WIN_BITS = 12,
   parameter int unsigned STATE_W  = 4,
   parameter int unsigned CTYPE_W  = 2,
   parameter int unsigned CNT_MSB  = 22,
   localparam int unsigned STRB_W  = DATA_W / 8,
   localparam int unsigned WORD_W  = WIN_BITS - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WORD_W-1:0]  wr_word,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [STRB_W-1:0]  wr_strb,
   input  logic [WORD_W-1:0]  rd_word,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               busy_i,
   input  logic               dma_err_i,
   input  logic [STATE_W-1:0] state_i,
   input  logic [CTYPE_W-1:0] card_type_i,
   input  logic [DATA_W-1:0]  progress_i,
   output logic [DATA_W-1:0]  dst_addr_o,
   output logic [DATA_W-1:0]  start_sector_o,
   output logic [DATA_W-1:0]  sector_count_o,
   output logic               start_o,
   output logic               soft_rst_o,
   output logic               irq_o,
   output logic               irq_pend,
   output logic               irq_en
);

   function automatic csr_sel_e pick(input logic [WORD_W-1:0] w);
      if (w[WORD_W-1:3] != '0) return SEL_NONE;
      case (w[2:0])
         3'd0:    return SEL_CTRL;
         3'd1:    return SEL_STAT;
         3'd2:    return SEL_DST;
         3'd3:    return SEL_SECT;
         3'd4:    return SEL_CNT;
         3'd5:    return SEL_PROG;
         3'd6:    return SEL_KICK;
         default: return SEL_NONE;
      endcase
   endfunction

   csr_sel_e wr_sel, rd_sel;
   assign wr_sel = pick(wr_word);
   assign rd_sel = pick(rd_word);

   // byte-lane mask from the strobes
   logic [DATA_W-1:0] lane_mask;
   for (genvar b = 0; b < STRB_W; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{wr_strb[b]}};
   end

   logic [DATA_W-1:0]  dst_q, sect_q;
   logic [CNT_MSB:1]   cnt_q;
   logic               ien_q, pend_q, go_q, kick_q, busy_q;
   logic [DATA_W-1:0]  dst_mrg, sect_mrg, cnt_mrg, cnt_full;
   logic               low_lane, go_req, kick_req, pend_clr, pend_set;

   always_comb begin
      cnt_full = '0;
      cnt_full[CNT_MSB:1] = cnt_q;
   end

   assign dst_mrg  = (dst_q & ~lane_mask)    | (wr_data & lane_mask);
   assign sect_mrg = (sect_q & ~lane_mask)   | (wr_data & lane_mask);
   assign cnt_mrg  = (cnt_full & ~lane_mask) | (wr_data & lane_mask);

   assign low_lane = wr_strb[0];
   assign go_req   = wr_en && (wr_sel == SEL_CTRL) && low_lane && wr_data[GO_BIT] && !busy_i;
   assign kick_req = wr_en && (wr_sel == SEL_KICK) && low_lane && wr_data[KICK_BIT];
   assign pend_clr = wr_en && (wr_sel == SEL_STAT) && low_lane && wr_data[PEND_BIT];
   assign pend_set = busy_q && !busy_i;

   // edge history of busy follows the input even in reset
   always_ff @(posedge clk) busy_q <= busy_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_q  <= '0;
         sect_q <= '0;
         cnt_q  <= '0;
         ien_q  <= 1'b0;
         pend_q <= 1'b0;
         go_q   <= 1'b0;
         kick_q <= 1'b0;
      end else begin
         go_q   <= go_req;
         kick_q <= kick_req;
         if (pend_set)      pend_q <= 1'b1;
         else if (pend_clr) pend_q <= 1'b0;
         if (wr_en) begin
            case (wr_sel)
               SEL_CTRL: if (low_lane) ien_q <= wr_data[IEN_BIT];
               SEL_DST:  dst_q  <= dst_mrg;
               SEL_SECT: sect_q <= sect_mrg;
               SEL_CNT:  cnt_q  <= cnt_mrg[CNT_MSB:1];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_CTRL: rd_data[IEN_BIT] = ien_q;
         SEL_STAT: begin
            rd_data[BUSY_BIT]                  = busy_i;
            rd_data[ERR_BIT]                   = dma_err_i;
            rd_data[PEND_BIT]                  = pend_q;
            rd_data[CTYPE_LSB +: CTYPE_W]      = card_type_i;
            rd_data[CSTATE_LSB +: STATE_W]     = state_i;
         end
         SEL_DST:  rd_data = dst_q;
         SEL_SECT: rd_data = sect_q;
         SEL_CNT:  rd_data = cnt_full;
         SEL_PROG: rd_data = progress_i;
         default:  rd_data = '0;
      endcase
   end

   assign dst_addr_o     = dst_q;
   assign start_sector_o = sect_q;
   assign sector_count_o = cnt_full;
   assign start_o        = go_q;
   assign soft_rst_o     = kick_q;
   assign irq_pend       = pend_q;
   assign irq_en         = ien_q;
   assign irq_o          = pend_q && ien_q;

endmodule

// File: rtl/dma_csr_axil.sv
module dma_csr_axil
   import dma_csr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned WIN_BITS = 12,
   parameter int unsigned STATE_W  = 4,
   parameter int unsigned CTYPE_W  = 2,
   parameter int unsigned CNT_MSB  = 22,
   localparam int unsigned STRB_W  = DATA_W / 8,
   localparam int unsigned WORD_W  = WIN_BITS - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  s_awaddr,
   input  logic               s_awvalid,
   output logic               s_awready,
   input  logic [DATA_W-1:0]  s_wdata,
   input  logic [STRB_W-1:0]  s_wstrb,
   input  logic               s_wvalid,
   output logic               s_wready,
   output logic [1:0]         s_bresp,
   output logic               s_bvalid,
   input  logic               s_bready,
   input  logic [ADDR_W-1:0]  s_araddr,
   input  logic               s_arvalid,
   output logic               s_arready,
   output logic [DATA_W-1:0]  s_rdata,
   output logic [1:0]         s_rresp,
   output logic               s_rvalid,
   input  logic               s_rready,
   input  logic               busy_i,
   input  logic               dma_err_i,
   input  logic [STATE_W-1:0] state_i,
   input  logic [CTYPE_W-1:0] card_type_i,
   input  logic [DATA_W-1:0]  progress_i,
   output logic [DATA_W-1:0]  dst_addr_o,
   output logic [DATA_W-1:0]  start_sector_o,
   output logic [DATA_W-1:0]  sector_count_o,
   output logic               start_o,
   output logic               soft_rst_o,
   output logic               irq_o
);

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_dw
      $error("dma_csr_axil: DATA_W must be 32");
   end
   if (WIN_BITS < 6 || WIN_BITS > ADDR_W) begin : g_bad_win
      $error("dma_csr_axil: WIN_BITS must cover the map and fit the address");
   end
   if (CTYPE_LSB + CTYPE_W > CSTATE_LSB) begin : g_bad_ctype
      $error("dma_csr_axil: card class field overlaps state field");
   end
   if (CSTATE_LSB + STATE_W > DATA_W) begin : g_bad_state
      $error("dma_csr_axil: state field exceeds word");
   end
   if (CNT_MSB >= DATA_W || CNT_MSB < 1) begin : g_bad_cnt
      $error("dma_csr_axil: sector count field out of range");
   end

   logic              wr_commit;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_look;
   logic [STRB_W-1:0] wr_strb;
   logic              irq_pend, irq_en;

   dma_csr_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bvalid(s_bvalid), .bready(s_bready),
      .commit(wr_commit), .commit_addr(wr_addr),
      .commit_data(wr_data), .commit_strb(wr_strb)
   );

   dma_csr_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
      .look_addr(rd_addr), .look_data(rd_look)
   );

   dma_csr_core #(
      .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .STATE_W(STATE_W),
      .CTYPE_W(CTYPE_W), .CNT_MSB(CNT_MSB)
   ) u_core (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_commit), .wr_word(wr_addr[WIN_BITS-1:2]),
      .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_word(rd_addr[WIN_BITS-1:2]), .rd_data(rd_look),
      .busy_i(busy_i), .dma_err_i(dma_err_i), .state_i(state_i),
      .card_type_i(card_type_i), .progress_i(progress_i),
      .dst_addr_o(dst_addr_o), .start_sector_o(start_sector_o),
      .sector_count_o(sector_count_o), .start_o(start_o),
      .soft_rst_o(soft_rst_o), .irq_o(irq_o),
      .irq_pend(irq_pend), .irq_en(irq_en)
   );

   // bits outside the register window and the byte offset are not decoded
   logic unused_addr;
   assign unused_addr = ^{wr_addr[1:0], rd_addr[1:0], wr_addr[ADDR_W-1:WIN_BITS], rd_addr[ADDR_W-1:WIN_BITS]};

   assign s_bresp = RESP_OKAY;
   assign s_rresp = RESP_OKAY;

endmodule

// File: rtl/dma_csr_sva.sv
module dma_csr_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        s_bvalid,
   input logic        s_bready,
   input logic        s_rvalid,
   input logic        s_rready,
   input logic [31:0] s_rdata,
   input logic        start_o,
   input logic        soft_rst_o,
   input logic        busy_i,
   input logic        irq_o,
   input logic        irq_pend,
   input logic        irq_en
);

   a_r2_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid && !s_bready |=> s_bvalid);

   a_r3_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid && !s_rready |=> s_rvalid);

   a_r3_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid && !s_rready |=> $stable(s_rdata));

   a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !$past(busy_i));

   a_r9_pend_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |=> irq_pend);

   a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_o);

   a_r11_soft_single: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);

endmodule

bind dma_csr_axil dma_csr_sva u_sva (
   .clk(clk), .rst_n(rst_n),
   .s_bvalid(s_bvalid), .s_bready(s_bready),
   .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
   .start_o(start_o), .soft_rst_o(soft_rst_o), .busy_i(busy_i),
   .irq_o(irq_o), .irq_pend(irq_pend), .irq_en(irq_en)
);

// File: tb/sim_dma_csr_axil.sv
module sim_dma_csr_axil;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] s_awaddr = '0, s_wdata = '0, s_araddr = '0;
   logic [3:0]  s_wstrb = '0;
   logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
   logic        s_arvalid = 1'b0, s_rready = 1'b0;
   logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0]  s_bresp, s_rresp;
   logic [31:0] s_rdata;
   logic        busy_i = 1'b0, dma_err_i = 1'b0;
   logic [3:0]  state_i = '0;
   logic [1:0]  card_type_i = '0;
   logic [31:0] progress_i = '0;
   logic [31:0] dst_addr_o, start_sector_o, sector_count_o;
   logic        start_o, soft_rst_o, irq_o;

   always #2 clk = ~clk;

   dma_csr_axil u0 (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
      .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
      .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
      .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
      .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
      .busy_i(busy_i), .dma_err_i(dma_err_i), .state_i(state_i),
      .card_type_i(card_type_i), .progress_i(progress_i),
      .dst_addr_o(dst_addr_o), .start_sector_o(start_sector_o),
      .sector_count_o(sector_count_o), .start_o(start_o),
      .soft_rst_o(soft_rst_o), .irq_o(irq_o)
   );

   int n_chk = 0, n_fail = 0;
   int n_start = 0, n_soft = 0, exp_start = 0, exp_soft = 0;
   bit mon_on = 1'b0;
   bit m_en = 1'b0, m_pend = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // pulse counters and per-clock interrupt model comparison (R10)
   always @(negedge clk) begin
      if (start_o) n_start++;
      if (soft_rst_o) n_soft++;
   end

   always @(negedge clk) begin
      #1;
      if (mon_on) chk("R10 irq_o vs model", {31'd0, irq_o}, {31'd0, m_en & m_pend});
   end

   task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] st, input int order);
      s_awaddr = a; s_wdata = d; s_wstrb = st;
      if (order == 0) begin
         s_awvalid = 1'b1; s_wvalid = 1'b1;
         while (!(s_awready && s_wready)) @(negedge clk);
         @(negedge clk);
         s_awvalid = 1'b0; s_wvalid = 1'b0;
      end else if (order == 1) begin
         s_awvalid = 1'b1;
         while (!s_awready) @(negedge clk);
         @(negedge clk);
         s_awvalid = 1'b0;
         repeat (3) @(negedge clk);
         chk("R2 no response before data", {31'd0, s_bvalid}, 32'd0);
         s_wvalid = 1'b1;
         while (!s_wready) @(negedge clk);
         @(negedge clk);
         s_wvalid = 1'b0;
      end else begin
         s_wvalid = 1'b1;
         while (!s_wready) @(negedge clk);
         @(negedge clk);
         s_wvalid = 1'b0;
         repeat (3) @(negedge clk);
         chk("R2 no response before address", {31'd0, s_bvalid}, 32'd0);
         s_awvalid = 1'b1;
         while (!s_awready) @(negedge clk);
         @(negedge clk);
         s_awvalid = 1'b0;
      end
      s_bready = 1'b1;
      while (!s_bvalid) @(negedge clk);
      chk("R2 bresp OKAY", {30'd0, s_bresp}, 32'd0);
      // behavioural model of the registers the interrupt depends on
      if (a == 32'h0 && st[0]) begin
         m_en = d[1];
         if (d[0] && !busy_i) exp_start++;
      end
      if (a == 32'h4 && st[0] && d[2]) m_pend = 1'b0;
      if (a == 32'h18 && st[0] && d[0]) exp_soft++;
      @(negedge clk);
      s_bready = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, input int hold, output logic [31:0] d);
      logic [31:0] d0;
      s_araddr = a; s_arvalid = 1'b1;
      while (!s_arready) @(negedge clk);
      @(negedge clk);
      s_arvalid = 1'b0;
      if (hold > 0) begin
         d0 = s_rdata;
         chk("R3 rvalid up", {31'd0, s_rvalid}, 32'd1);
         repeat (hold) @(negedge clk);
         chk("R3 rvalid held", {31'd0, s_rvalid}, 32'd1);
         chk("R3 rdata stable", s_rdata, d0);
      end
      s_rready = 1'b1;
      while (!s_rvalid) @(negedge clk);
      d = s_rdata;
      chk("R3 rresp OKAY", {30'd0, s_rresp}, 32'd0);
      @(negedge clk);
      s_rready = 1'b0;
   endtask

   task automatic end_busy();
      busy_i = 1'b0;
      @(negedge clk);
      m_pend = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      chk("R1 bvalid in reset", {31'd0, s_bvalid}, 32'd0);
      chk("R1 rvalid in reset", {31'd0, s_rvalid}, 32'd0);
      chk("R1 irq in reset", {31'd0, irq_o}, 32'd0);
      chk("R1 pulses in reset", {30'd0, start_o, soft_rst_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      rd(32'h00, 0, v); chk("R1 ctrl reset", v, 32'h0);
      rd(32'h08, 0, v); chk("R1 dst reset", v, 32'h0);
      rd(32'h10, 0, v); chk("R1 count reset", v, 32'h0);
      rd(32'h04, 0, v); chk("R8 status idle", v, 32'h0);

      // R4 full registers, three write orders, byte strobes
      wr(32'h08, 32'hDEADBEEF, 4'hF, 0);
      rd(32'h08, 0, v); chk("R4 dst", v, 32'hDEADBEEF);
      chk("R4 dst port", dst_addr_o, 32'hDEADBEEF);
      wr(32'h0C, 32'h12345678, 4'hF, 1);
      rd(32'h0C, 0, v); chk("R4 sector", v, 32'h12345678);
      chk("R4 dst untouched", dst_addr_o, 32'hDEADBEEF);
      wr(32'h08, 32'hFFFFFFFF, 4'b0101, 2);
      rd(32'h08, 0, v); chk("R4 strobes", v, 32'hDEFFBEFF);

      // R5 sector count field
      wr(32'h10, 32'hFFFFFFFF, 4'hF, 2);
      rd(32'h10, 0, v); chk("R5 count field", v, 32'h007FFFFE);
      chk("R5 count port", sector_count_o, 32'h007FFFFE);

      // R6 start while idle and enable
      wr(32'h00, 32'h3, 4'h1, 0);
      @(negedge clk);
      chk("R6 one start pulse", n_start, exp_start);
      chk("R6 one start pulse abs", n_start, 1);
      rd(32'h00, 0, v); chk("R6 ctrl readback", v, 32'h2);

      // R8 status layout
      busy_i = 1'b1; dma_err_i = 1'b1; state_i = 4'hA; card_type_i = 2'd2;
      @(negedge clk);
      rd(32'h04, 0, v); chk("R8 status busy", v, 32'h153);

      // R7 start while busy
      wr(32'h00, 32'h3, 4'h1, 1);
      @(negedge clk);
      chk("R7 no start when busy", n_start, 1);

      // R9 pending on busy fall, W1C
      end_busy();
      chk("R9 irq after fall", {31'd0, irq_o}, 32'd1);
      rd(32'h04, 0, v); chk("R9 pending set", v, 32'h156);
      wr(32'h04, 32'hFFFFFFFB, 4'hF, 0);
      rd(32'h04, 0, v); chk("R9 write 0 keeps", v, 32'h156);
      wr(32'h04, 32'h4, 4'h1, 0);
      rd(32'h04, 0, v); chk("R9 write 1 clears", v, 32'h152);
      chk("R9 irq cleared", {31'd0, irq_o}, 32'd0);

      // R10 masking
      wr(32'h00, 32'h0, 4'h1, 0);
      busy_i = 1'b1;
      @(negedge clk);
      end_busy();
      chk("R10 masked irq", {31'd0, irq_o}, 32'd0);
      rd(32'h04, 0, v); chk("R10 pending while masked", v[2], 1'b1);
      wr(32'h00, 32'h2, 4'h1, 2);
      chk("R10 unmask irq", {31'd0, irq_o}, 32'd1);
      wr(32'h04, 32'h4, 4'h1, 0);
      chk("R6 no start from bit1 writes", n_start, exp_start);

      // R11 soft reset
      wr(32'h18, 32'h1, 4'h1, 0);
      @(negedge clk);
      chk("R11 one soft pulse", n_soft, 1);
      chk("R11 model", n_soft, exp_soft);
      rd(32'h18, 0, v); chk("R11 reads 0", v, 32'h0);

      // R12 progress and ignored writes
      progress_i = 32'h00ABCDEF;
      wr(32'h14, 32'hFFFFFFFF, 4'hF, 0);
      rd(32'h14, 0, v); chk("R12 progress", v, 32'h00ABCDEF);
      wr(32'h100, 32'h55, 4'hF, 1);
      rd(32'h08, 0, v); chk("R12 unmapped write ignored", v, 32'hDEFFBEFF);
      rd(32'h0C, 0, v); chk("R12 sector unchanged", v, 32'h12345678);

      // R3 holding read response, unmapped reads
      rd(32'h0C, 4, v); chk("R3 held read data", v, 32'h12345678);
      rd(32'h100, 0, v); chk("R3 unmapped 0x100", v, 32'h0);
      rd(32'h1C, 2, v); chk("R3 unmapped 0x1C", v, 32'h0);

      repeat (4) @(negedge clk);
      mon_on = 1'b0;
      summary();
      $finish;
   end

endmodule